// File: doc/BRIEF.md
# Nibble-Serial Register Access Decoder

This block sits behind a byte-wide FIFO bridge on the device side of a link. The host drives register traffic as a stream of command bytes. The upper four bits of each byte select an operation and the lower four bits carry a nibble of payload. The decoder assembles an 8-bit register address from two address bytes, one for each nibble. It builds each write value from a low-nibble byte, which is staged, followed by a high-nibble byte that commits the write. It holds a small internal register file and reports every write on a one-cycle strobe with address and data.

A read command returns the byte at the current address on a response stream that supports backpressure. If bit 0 of the read payload is set, the address moves on by one after the read. The host can then fetch multi-byte values, such as two 24-bit capture positions stored least significant byte first, with a run of identical read commands. Writes also advance the address, so one address pair can be followed by a burst of data pairs. The address given applies to the first data byte of the burst.

Top module: `nibreg_decoder`

## Requirements
- R1: After reset, `wr_stb` and `out_valid` are 0, `in_ready` is 1, the address is 0x00 and every implemented register reads 0x00.
- R2: Command code 0x4 (bits 7:4) loads the payload into address bits 3:0, and code 0x5 loads it into address bits 7:4. The other nibble is left unchanged.
- R3: Code 0x6 stages the payload as the low data nibble and produces no write strobe.
- R4: Code 0x7 writes {payload, staged nibble} to the current address. One cycle after that byte is accepted, `wr_stb` is 1 for exactly one cycle with `wr_addr` and `wr_data` showing that write.
- R5: Each write advances the address by one, wrapping from 0xFF to 0x00. The first data pair of a burst goes to the address that was sent, and later pairs go to the following addresses.
- R6: Code 0x8 with payload bit 0 clear returns the byte at the current address. `out_valid` and `out_data` appear one cycle after acceptance, and the address is unchanged.
- R7: Code 0x8 with payload bit 0 set returns the byte at the current address and then advances the address by one. Six such reads return six consecutive registers in address order.
- R8: Only addresses below NUM_REGS (default 16) are stored. A read of any other address returns 0x00, and a write to one leaves storage untouched but still pulses `wr_stb`.
- R9: A byte whose code is not 0x4 to 0x8 is consumed with no strobe, no response and no change to address or staged nibble.
- R10: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_data` holds its value. When `out_ready` returns, a waiting input byte is accepted in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Command byte present |
| in_data | input | 8 | Command byte: code in 7:4, payload in 3:0 |
| in_ready | output | 1 | Decoder accepts the byte this cycle |
| out_valid | output | 1 | Response byte present |
| out_data | output | 8 | Response byte |
| out_ready | input | 1 | Consumer takes the response byte |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_addr | output | 8 | Address of the reported write |
| wr_data | output | 8 | Data of the reported write |

## Verification
The assertions check the following on every cycle: the stream handshake, which stalls input and freezes a response held under backpressure; that each strobe or new response traces back to an accepted write or read command; and that unknown codes stay silent. Address assembly, the increment after writes and after flagged reads, wrapping, the zero result above the implemented range, and byte order in a six-read sequence are all hidden state seen only through returned values. Only the bench's command scenarios can show them.

// File: rtl/nibreg_pkg.sv
package nibreg_pkg;

    localparam int NIB_W  = 4;
    localparam int BYTE_W = 2 * NIB_W;

    typedef enum logic [NIB_W-1:0] {
        OP_ADDR_LO = 4'h4,
        OP_ADDR_HI = 4'h5,
        OP_DATA_LO = 4'h6,
        OP_DATA_WR = 4'h7,
        OP_READ    = 4'h8
    } op_e;

    typedef struct packed {
        logic             set_alo;
        logic             set_ahi;
        logic             set_dlo;
        logic             do_wr;
        logic             do_rd;
        logic             rd_next;
        logic [NIB_W-1:0] nib;
    } cmd_t;

    function automatic cmd_t decode_byte(input logic fire, input logic [BYTE_W-1:0] b);
        cmd_t c;
        c         = '0;
        c.nib     = b[NIB_W-1:0];
        if (fire) begin
            case (b[BYTE_W-1:NIB_W])
                OP_ADDR_LO: c.set_alo = 1'b1;
                OP_ADDR_HI: c.set_ahi = 1'b1;
                OP_DATA_LO: c.set_dlo = 1'b1;
                OP_DATA_WR: c.do_wr   = 1'b1;
                OP_READ: begin
                    c.do_rd   = 1'b1;
                    c.rd_next = b[0];
                end
                default: ;
            endcase
        end
        return c;
    endfunction

    function automatic logic is_known_op(input logic [NIB_W-1:0] op);
        return (op >= OP_ADDR_LO) && (op <= OP_READ);
    endfunction

endpackage

// File: rtl/nibreg_cmd_dec.sv
module nibreg_cmd_dec
    import nibreg_pkg::*;
(
    input  logic              fire,
    input  logic [BYTE_W-1:0] byte_in,
    output cmd_t              cmd
);
    always_comb cmd = decode_byte(fire, byte_in);
endmodule

// File: rtl/nibreg_addr_ctl.sv
module nibreg_addr_ctl
    import nibreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cmd_t              cmd,
    output logic [BYTE_W-1:0] cur_addr,
    output logic              wr_req,
    output logic [BYTE_W-1:0] wr_val
);
    logic [NIB_W-1:0] dlo_q;

    assign wr_req = cmd.do_wr;
    assign wr_val = {cmd.nib, dlo_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr <= '0;
            dlo_q    <= '0;
        end else begin
            if (cmd.set_alo) cur_addr[NIB_W-1:0]      <= cmd.nib;
            if (cmd.set_ahi) cur_addr[BYTE_W-1:NIB_W] <= cmd.nib;
            if (cmd.set_dlo) dlo_q                    <= cmd.nib;
            if (cmd.do_wr || (cmd.do_rd && cmd.rd_next))
                cur_addr <= cur_addr + 1'b1;
        end
    end
endmodule

// File: rtl/nibreg_regfile.sv
module nibreg_regfile
    import nibreg_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [BYTE_W-1:0] waddr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [BYTE_W-1:0] raddr,
    output logic [BYTE_W-1:0] rdata
);
    logic [BYTE_W-1:0] q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                q[g] <= '0;
            else if (we && (waddr == BYTE_W'(g)))
                q[g] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (raddr == BYTE_W'(i)) rdata = q[i];
    end
endmodule

// File: rtl/nibreg_resp.sv
module nibreg_resp
    import nibreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_data,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= load_data;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/nibreg_decoder.sv
module nibreg_decoder
    import nibreg_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    input  logic              out_ready,
    output logic              wr_stb,
    output logic [BYTE_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data
);
    cmd_t              cmd;
    logic              fire;
    logic [BYTE_W-1:0] cur_addr;
    logic              wr_req;
    logic [BYTE_W-1:0] wr_val;
    logic [BYTE_W-1:0] rd_val;

    assign in_ready = !rst && !(out_valid && !out_ready);
    assign fire     = in_valid && in_ready;

    nibreg_cmd_dec u_dec (
        .fire    (fire),
        .byte_in (in_data),
        .cmd     (cmd)
    );

    nibreg_addr_ctl u_addr (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .cur_addr (cur_addr),
        .wr_req   (wr_req),
        .wr_val   (wr_val)
    );

    nibreg_regfile #(.NUM_REGS(NUM_REGS)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_req),
        .waddr (cur_addr),
        .wdata (wr_val),
        .raddr (cur_addr),
        .rdata (rd_val)
    );

    nibreg_resp u_resp (
        .clk       (clk),
        .rst       (rst),
        .load      (cmd.do_rd),
        .load_data (rd_val),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_stb  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_stb <= wr_req;
            if (wr_req) begin
                wr_addr <= cur_addr;
                wr_data <= wr_val;
            end
        end
    end
endmodule

// File: rtl/nibreg_decoder_chk.sv
module nibreg_decoder_chk
    import nibreg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [BYTE_W-1:0] in_data,
    input logic              in_ready,
    input logic              out_valid,
    input logic [BYTE_W-1:0] out_data,
    input logic              out_ready,
    input logic              wr_stb
);
    logic acc;
    assign acc = in_valid && in_ready;

    // R10
    stall_in_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    // R10
    hold_resp_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R4
    wr_origin_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> $past(acc && (in_data[7:4] == OP_DATA_WR)));

    // R4
    wr_single_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && !$past(acc)) |=> !wr_stb);

    // R6
    resp_origin_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(acc && (in_data[7:4] == OP_READ)));

    // R9
    unknown_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && !is_known_op(in_data[7:4])) |=> (!wr_stb && !$rose(out_valid)));
endmodule

bind nibreg_decoder nibreg_decoder_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ready (out_ready),
    .wr_stb    (wr_stb)
);

// File: tb/nibreg_decoder_tb.sv
module nibreg_decoder_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid;
    logic [7:0] in_data;
    logic       in_ready;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_ready;
    logic       wr_stb;
    logic [7:0] wr_addr;
    logic [7:0] wr_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    nibreg_decoder u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
        .out_ready(out_ready), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    // kind: 0 = nothing, 1 = write strobe {addr,data}, 2 = response byte
    localparam int NV = 49;
    localparam logic [25:0] VEC [NV] = '{
        {8'h41,2'd0,16'h0000}, {8'h50,2'd0,16'h0000}, {8'h6A,2'd0,16'h0000}, // R2 R3
        {8'h75,2'd1,16'h015A}, {8'h63,2'd0,16'h0000}, {8'h7C,2'd1,16'h02C3}, // R4 R5
        {8'h41,2'd0,16'h0000}, {8'h80,2'd2,16'h005A}, {8'h80,2'd2,16'h005A}, // R6
        {8'h81,2'd2,16'h005A}, {8'h80,2'd2,16'h00C3},                        // R7
        {8'h20,2'd0,16'h0000}, {8'h80,2'd2,16'h00C3},                        // R9
        {8'hF5,2'd0,16'h0000}, {8'h80,2'd2,16'h00C3},                        // R9
        {8'h40,2'd0,16'h0000}, {8'h52,2'd0,16'h0000}, {8'h61,2'd0,16'h0000},
        {8'h7F,2'd1,16'h20F1}, {8'h40,2'd0,16'h0000}, {8'h52,2'd0,16'h0000},
        {8'h80,2'd2,16'h0000},                                               // R8
        {8'h4F,2'd0,16'h0000}, {8'h5F,2'd0,16'h0000}, {8'h60,2'd0,16'h0000},
        {8'h70,2'd1,16'hFF00}, {8'h80,2'd2,16'h0000},                        // R5 wrap
        {8'h48,2'd0,16'h0000}, {8'h50,2'd0,16'h0000},
        {8'h61,2'd0,16'h0000}, {8'h71,2'd1,16'h0811},
        {8'h62,2'd0,16'h0000}, {8'h72,2'd1,16'h0922},
        {8'h63,2'd0,16'h0000}, {8'h73,2'd1,16'h0A33},
        {8'h64,2'd0,16'h0000}, {8'h74,2'd1,16'h0B44},
        {8'h65,2'd0,16'h0000}, {8'h75,2'd1,16'h0C55},
        {8'h66,2'd0,16'h0000}, {8'h76,2'd1,16'h0D66},
        {8'h48,2'd0,16'h0000}, {8'h50,2'd0,16'h0000},
        {8'h81,2'd2,16'h0011}, {8'h81,2'd2,16'h0022}, {8'h81,2'd2,16'h0033}, // R7
        {8'h81,2'd2,16'h0044}, {8'h81,2'd2,16'h0055}, {8'h81,2'd2,16'h0066}
    };

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_read(input logic [7:0] exp, input string req);
        check(out_valid === 1'b1 && out_data === exp, req, {7'd0, out_valid, out_data}, {8'h01, exp});
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_data = '0; out_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(in_ready === 1'b1 && out_valid === 1'b0 && wr_stb === 1'b0, "R1",
              {13'd0, in_ready, out_valid, wr_stb}, 16'h0004);

        for (int i = 0; i < NV; i++) begin
            send(VEC[i][25:18]);
            case (VEC[i][17:16])
                2'd0: check(!wr_stb && !out_valid, "R2/R3/R9 no effect",
                            {14'd0, wr_stb, out_valid}, 16'h0000);
                2'd1: check(wr_stb && !out_valid && {wr_addr, wr_data} === VEC[i][15:0],
                            "R4/R5 write", {wr_addr, wr_data}, VEC[i][15:0]);
                default: expect_read(VEC[i][7:0], "R6/R7/R8 read");
            endcase
        end
        // R4: strobe lasts one cycle
        send(8'h6F); send(8'h7E);
        @(negedge clk);
        check(wr_stb === 1'b0, "R4 single pulse", {15'd0, wr_stb}, 16'h0000);

        // R10 backpressure
        send(8'h49); send(8'h50);
        out_ready = 1'b0;
        send(8'h81);
        expect_read(8'h22, "R10 first");
        check(in_ready === 1'b0, "R10 stall", {15'd0, in_ready}, 16'h0000);
        in_valid = 1'b1; in_data = 8'h80;
        @(negedge clk); @(negedge clk);
        expect_read(8'h22, "R10 hold");
        check(in_ready === 1'b0, "R10 stall held", {15'd0, in_ready}, 16'h0000);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        expect_read(8'h33, "R10 release");
        @(negedge clk);
        check(out_valid === 1'b0, "R10 drained", {15'd0, out_valid}, 16'h0000);

        // R1 reset clears registers and address
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        send(8'h80);
        expect_read(8'h00, "R1 addr0 after reset");
        send(8'h49); send(8'h50); send(8'h80);
        expect_read(8'h00, "R1 reg cleared");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule